// File: doc/BRIEF.md
# USB Interrupt Status, Mask and Acknowledge Unit

This block collects single-cycle event pulses from a USB device core and turns them into sticky flags that firmware can read through a small register port. It keeps two groups of flags. The first group holds frame and endpoint events: start of frame, the late end-of-frame marker (EOF2), hub endpoint 0 and function endpoints 0 to 2. The second group holds bus power-state events: global suspend, resume and function remote wakeup.

Each group has its own gating register, and the two gating registers have opposite polarity. A one in the event mask blocks a source. A one in the suspend/resume enable lets a source through. The two groups are also cleared differently. An event flag clears only through a separate write-one acknowledge register. A suspend/resume flag clears when a one is written to its own bit. The block drives a single level interrupt to the microcontroller core. That line is high while any flag is pending and allowed through its gating register.

Register map (3-bit word address): 0 event status, 1 event mask, 2 event acknowledge, 3 suspend/resume status, 4 suspend/resume enable. The other addresses read zero and ignore writes. Event bit order, in all three event registers: bit 0 function endpoint 0, bit 1 function endpoint 1, bit 2 function endpoint 2, bit 3 hub endpoint 0, bit 4 EOF2, bit 5 start of frame. Suspend/resume bit order: bit 0 global suspend, bit 1 resume, bit 2 function remote wakeup. Register bits above these read zero. A read returns its data in the same cycle as the address. A write takes effect at the next rising clock edge.

Top module: `usb_irq_hub`

## Requirements
- R1: After reset, every status flag is zero, the event mask reads 0x3F, the suspend/resume enable reads 0x00, and irq is low.
- R2: An event pulse sets its bit in the event status register (address 0) at the next clock edge. The bit stays set until it is acknowledged.
- R3: A write to the event status register (address 0) changes none of its bits.
- R4: Writing to the acknowledge register (address 2) clears each event status bit where the written data has a one. Bits where the written data has a zero keep their value.
- R5: The acknowledge register always reads as zero.
- R6: A pending event flag drives irq only while its mask bit (address 1) is 0. Setting the mask bit to 1 blocks that flag from irq but leaves the flag itself set.
- R7: The global suspend, resume and remote wakeup pulses set bits 0, 1 and 2 of the suspend/resume status register (address 3) at the next clock edge.
- R8: Writing to address 3 clears each suspend/resume flag where the written data has a one. Bits written with zero keep their value.
- R9: A pending suspend/resume flag drives irq only while its enable bit (address 4) is 1.
- R10: If a flag's event pulse and a clear of that flag arrive in the same cycle, the flag ends up set.
- R11: irq is a level. It equals the OR of all pending event flags whose mask bit is 0 and all pending suspend/resume flags whose enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| ev_sof | input | 1 | Start-of-frame decoded pulse |
| ev_eof2 | input | 1 | EOF2 point pulse |
| ev_hep0 | input | 1 | Hub endpoint 0 event pulse |
| ev_fep | input | 3 | Function endpoint 0..2 event pulses |
| ev_gsusp | input | 1 | Global suspend detected pulse |
| ev_resume | input | 1 | Resume detected pulse |
| ev_rwake | input | 1 | Function remote wakeup pulse |
| irq | output | 1 | Combined interrupt level |

## Verification
The bench goes after the cases where the two groups differ.

- A design that treated direct writes to event status as clears would lose flags after a write to address 0.
- A design with the mask polarity flipped would raise irq at reset or stay silent when a mask bit is cleared.
- A design where a clear beats a coincident event would drop that event for good. The bench schedules an event and an acknowledge of the same bit in one cycle, and does the same for the suspend/resume group.
- A design that read the acknowledge register back as stored data would show nonzero values at address 2.

Random traffic then mixes writes, reads and event bursts against a reference model kept in the bench.

// File: rtl/usb_irq_hub.sv
module usb_irq_hub #(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int NEV = 6,
  parameter int NSR = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_sof,
  input  logic          ev_eof2,
  input  logic          ev_hep0,
  input  logic [2:0]    ev_fep,
  input  logic          ev_gsusp,
  input  logic          ev_resume,
  input  logic          ev_rwake,
  output logic          irq
);
  localparam logic [AW-1:0] A_EVST = AW'(0);
  localparam logic [AW-1:0] A_EVMK = AW'(1);
  localparam logic [AW-1:0] A_EVAK = AW'(2);
  localparam logic [AW-1:0] A_SRST = AW'(3);
  localparam logic [AW-1:0] A_SREN = AW'(4);

  logic [NEV-1:0] ev_vec, evt_stat, evt_mask, ack_clr;
  logic [NSR-1:0] sr_vec, sr_stat, sr_en, sr_clr;

  assign ev_vec  = {ev_sof, ev_eof2, ev_hep0, ev_fep};
  assign sr_vec  = {ev_rwake, ev_resume, ev_gsusp};
  assign ack_clr = (reg_we && reg_addr == A_EVAK) ? reg_wdata[NEV-1:0] : '0;
  assign sr_clr  = (reg_we && reg_addr == A_SRST) ? reg_wdata[NSR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_stat <= '0;
      evt_mask <= '1;
      sr_stat  <= '0;
      sr_en    <= '0;
    end else begin
      evt_stat <= (evt_stat & ~ack_clr) | ev_vec;
      sr_stat  <= (sr_stat & ~sr_clr) | sr_vec;
      if (reg_we && reg_addr == A_EVMK) evt_mask <= reg_wdata[NEV-1:0];
      if (reg_we && reg_addr == A_SREN) sr_en    <= reg_wdata[NSR-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EVST:  reg_rdata = {{(DW-NEV){1'b0}}, evt_stat};
      A_EVMK:  reg_rdata = {{(DW-NEV){1'b0}}, evt_mask};
      A_SRST:  reg_rdata = {{(DW-NSR){1'b0}}, sr_stat};
      A_SREN:  reg_rdata = {{(DW-NSR){1'b0}}, sr_en};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (|(evt_stat & ~evt_mask)) | (|(sr_stat & sr_en));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    |ev_vec |=> ((evt_stat & $past(ev_vec)) == $past(ev_vec)));

  a_r3_direct_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EVST && ev_vec == '0) |=> $stable(evt_stat));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EVAK && ev_vec == '0) |=>
      ((evt_stat & $past(reg_wdata[NEV-1:0])) == '0));

  a_r5_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_EVAK) |-> (reg_rdata == '0));

  a_r8_sr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SRST && sr_vec == '0) |=>
      ((sr_stat & $past(reg_wdata[NSR-1:0])) == '0));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|sr_vec) |=> ((sr_stat & $past(sr_vec)) == $past(sr_vec)));

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_stat != '0 || sr_stat != '0));
endmodule

// File: tb/sim_usb_irq_hub.sv
`timescale 1ns/100ps
module sim_usb_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] evv = '0;
  logic [2:0] srv = '0;
  logic       irq;
  int tests = 0;
  int fails = 0;

  logic [5:0] m_evt, m_mask;
  logic [2:0] m_sr, m_en;

  always #2.5 clk = ~clk;

  usb_irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_sof(evv[5]), .ev_eof2(evv[4]), .ev_hep0(evv[3]), .ev_fep(evv[2:0]),
    .ev_gsusp(srv[0]), .ev_resume(srv[1]), .ev_rwake(srv[2]), .irq(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {2'b0, m_evt};
      3'd1: return {2'b0, m_mask};
      3'd3: return {5'b0, m_sr};
      3'd4: return {5'b0, m_en};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_evt & ~m_mask)) | (|(m_sr & m_en));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, reg_rdata, exp_rd(reg_addr));
    chk("R11 irq", {7'b0, irq}, {7'b0, exp_irq()});
  endtask

  task automatic cyc(input logic [2:0] a, input logic we, input logic [7:0] wd,
                     input logic [5:0] ev, input logic [2:0] sr, input string tag);
    @(negedge clk);
    reg_addr = a; reg_we = we; reg_wdata = wd; evv = ev; srv = sr;
    @(posedge clk);
    #1;
    m_evt = (m_evt & ~((we && a == 3'd2) ? wd[5:0] : 6'h0)) | ev;
    m_sr  = (m_sr  & ~((we && a == 3'd3) ? wd[2:0] : 3'h0)) | sr;
    if (we && a == 3'd1) m_mask = wd[5:0];
    if (we && a == 3'd4) m_en = wd[2:0];
    check_all(tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_evt = '0; m_mask = 6'h3F; m_sr = '0; m_en = '0;
    #12 rst_n = 1'b1;
    for (int a = 0; a < 5; a++) cyc(3'(a), 1'b0, 8'h00, 6'h0, 3'h0, "R1 reset");
    chk("R1 mask", reg_rdata, 8'h00);
    // R2: sof and fep1 set
    cyc(3'd0, 1'b0, 8'h00, 6'h22, 3'h0, "R2 event set");
    chk("R2 value", reg_rdata, 8'h22);
    // R6: masked -> no irq
    chk("R6 masked irq", {7'b0, irq}, 8'h00);
    // R3: direct write ignored
    cyc(3'd0, 1'b1, 8'hFF, 6'h0, 3'h0, "R3 direct write");
    chk("R3 value", reg_rdata, 8'h22);
    // R6: unmask sof
    cyc(3'd1, 1'b1, 8'h1F, 6'h0, 3'h0, "R6 unmask");
    chk("R6 irq", {7'b0, irq}, 8'h01);
    // R4: ack fep1 only
    cyc(3'd2, 1'b1, 8'h02, 6'h0, 3'h0, "R5 ack read");
    chk("R5 zero", reg_rdata, 8'h00);
    cyc(3'd0, 1'b0, 8'h00, 6'h0, 3'h0, "R4 partial ack");
    chk("R4 value", reg_rdata, 8'h20);
    // R10: ack and event on sof together
    cyc(3'd2, 1'b1, 8'h20, 6'h20, 3'h0, "R10 same cycle");
    cyc(3'd0, 1'b0, 8'h00, 6'h0, 3'h0, "R10 set wins");
    chk("R10 value", reg_rdata, 8'h20);
    cyc(3'd2, 1'b1, 8'h3F, 6'h0, 3'h0, "R4 full ack");
    chk("R4 irq low", {7'b0, irq}, 8'h00);
    // R7/R9: suspend group
    cyc(3'd3, 1'b0, 8'h00, 6'h0, 3'h5, "R7 sr set");
    chk("R7 value", reg_rdata, 8'h05);
    chk("R9 disabled irq", {7'b0, irq}, 8'h00);
    cyc(3'd4, 1'b1, 8'h04, 6'h0, 3'h0, "R9 enable");
    chk("R9 irq", {7'b0, irq}, 8'h01);
    // R8: clear bit 2 and R10 for sr on bit 0
    cyc(3'd3, 1'b1, 8'h05, 6'h0, 3'h1, "R8 sr clear");
    chk("R8 value", reg_rdata, 8'h01);
    chk("R8 irq", {7'b0, irq}, 8'h00);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic [5:0] ev;
      logic [2:0] sr;
      a  = 3'($urandom_range(0, 7));
      ev = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
      sr = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'h0;
      case (a)
        3'd0: cyc(a, 1'($urandom), 8'($urandom), ev, sr, "R2/R3 random");
        3'd1: cyc(a, 1'($urandom), 8'($urandom), ev, sr, "R6 random");
        3'd2: cyc(a, 1'($urandom), 8'($urandom), ev, sr, "R4/R5 random");
        3'd3: cyc(a, 1'($urandom), 8'($urandom), ev, sr, "R7/R8 random");
        3'd4: cyc(a, 1'($urandom), 8'($urandom), ev, sr, "R9 random");
        default: cyc(a, 1'($urandom), 8'($urandom), ev, sr, "R11 random");
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule